// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the software-visible register front end of a platform interrupt controller. It takes a simple single-cycle 32-bit read/write request and decodes it into four address regions. The regions are source priorities, the pending bitmap, one enable bitmap per context, and one threshold and claim/complete pair per context. It holds the priority, enable and threshold storage, and drives that storage to a separate arbiter as flat vectors. Toward the arbiter it also issues a claim strobe when software reads a claim register, and a complete strobe when software writes one.

The arbiter supplies the pending bits and, for each context, the ID it would hand out on a claim. This block picks no winners and drives no interrupt lines. All region bases, strides, source and context counts and the priority width are parameters. Data words are little-endian: bit 0 of the data bus is the least significant bit of byte 0. Bit j of bitmap word w always refers to source 32·w + j.

A read is answered in the cycle after its request, through a registered data-valid. The claim side effect is therefore tied to one request cycle and happens exactly once for each read.

Top module: `intc_reg_decoder`

## Requirements
- R1: An access whose two low address bits are not both zero is invalid. It raises `err_o` for one cycle, one cycle after the request. A misaligned read returns 0. A misaligned write changes no priority, enable or threshold state.
- R2: The word at PRIO_BASE + 4·k holds the priority of source k+1, for k in 0..NUM_SRC-1. A write stores only the low PRIO_W (3) bits of the data. A read returns the stored value, zero-extended.
- R3: The word at PEND_BASE + 4·w returns `pend_i` bits 32·w to 32·w+31, with bit j of the word being source 32·w+j and the bits above NUM_SRC reading 0. A write there raises the error and changes nothing.
- R4: Context c has its enable bitmap at ENA_BASE + c·ENA_STRIDE, with word w at offset 4·w. A word is read and written whole. On `enable_o` it appears at bits (c·WORDS+w)·32 and upward. An offset whose word index is WORDS or more is an invalid access.
- R5: The threshold of context c is at CTX_BASE + c·CTX_STRIDE + 0. A write whose 32-bit value exceeds MAX_PRIO (7) is ignored without error. Any other write is stored, and a read returns the stored value. It appears on `thresh_o` at bits c·PRIO_W and upward.
- R6: A read at context offset 4 pulses `claim_stb_o` for the single request cycle with `claim_ctx_o` = c. The following response returns that context's `best_id_i` field, which sits at bits c·ID_W and upward.
- R7: A write at context offset 4 whose value is at most NUM_SRC pulses `cmpl_stb_o` in the request cycle, with `cmpl_ctx_o` = c and `cmpl_id_o` = the written value. A larger value gives no strobe and no error.
- R8: An aligned address outside every region is invalid, and so is a context offset other than 0 or 4. Invalid reads return 0 with `err_o`. Invalid writes change nothing.
- R9: `rvalid_o` rises for exactly one cycle, one cycle after each read request, and never for a write. `err_o` is only ever set in a cycle that follows a request.
- R10: After reset, all priorities, enables and thresholds are zero and `rvalid_o`, `err_o` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read response valid |
| rdata_o | output | 32 | Read response data |
| err_o | output | 1 | Invalid-access pulse, aligned with the response cycle |
| pend_i | input | NUM_SRC+1 | Pending bit per source ID (bit 0 unused by sources) |
| best_id_i | input | NUM_CTX·ID_W | Per-context ID that a claim would return |
| claim_stb_o | output | 1 | Claim request to the arbiter |
| claim_ctx_o | output | CTX_W | Context of the claim |
| cmpl_stb_o | output | 1 | Completion notice to the arbiter |
| cmpl_ctx_o | output | CTX_W | Context of the completion |
| cmpl_id_o | output | ID_W | Completed source ID |
| prio_o | output | (NUM_SRC+1)·PRIO_W | Priority per source ID, slot 0 zero |
| enable_o | output | NUM_CTX·WORDS·32 | Enable bitmaps of all contexts |
| thresh_o | output | NUM_CTX·PRIO_W | Threshold per context |

## Verification
The assertions assume that `req_i`, `we_i` and the address are known whenever the block is out of reset. They also assume that `best_id_i` never exceeds NUM_SRC, because a claim response reflects it directly. The stimulus holds every input at a defined value from time zero and issues one request followed by one idle cycle. That spacing keeps each response unambiguously paired with its request. The arbiter inputs are driven by the bench from fixed per-test values that stay inside the source range.

// File: rtl/intc_reg_pkg.sv
// Package intc_reg_pkg
// Shared types of the interrupt controller register decoder.
// Assumes: nothing beyond the 32-bit data bus.
package intc_reg_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned WORD_BYTES = 4;

    // Region selected by a decoded address
    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_PRIO  = 3'd1,
        RG_PEND  = 3'd2,
        RG_ENA   = 3'd3,
        RG_THR   = 3'd4,
        RG_CLAIM = 3'd5
    } region_e;

endpackage

// File: rtl/intc_addr_decode.sv
// Module intc_addr_decode
// Combinational address decoder. Maps a byte address to a region and
// extracts the source, context and word indices for that region.
// Assumes: strides are powers of two, regions do not overlap, and each
// region span fits in ADDR_W bits.
module intc_addr_decode
    import intc_reg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned NUM_SRC    = 40,
    parameter int unsigned NUM_CTX    = 2,
    parameter int unsigned WORDS      = 2,
    parameter int unsigned PRIO_BASE  = 'h0,
    parameter int unsigned PEND_BASE  = 'h1000,
    parameter int unsigned ENA_BASE   = 'h2000,
    parameter int unsigned ENA_STRIDE = 'h80,
    parameter int unsigned CTX_BASE   = 'h200000,
    parameter int unsigned CTX_STRIDE = 'h1000,
    parameter int unsigned SRC_W      = 6,
    parameter int unsigned CTX_W      = 1,
    parameter int unsigned WRD_W      = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output region_e           region_o,
    output logic              ok_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [CTX_W-1:0]  ctx_o,
    output logic [WRD_W-1:0]  word_o
);

    localparam int unsigned ESH = $clog2(ENA_STRIDE);
    localparam int unsigned CSH = $clog2(CTX_STRIDE);

    localparam logic [ADDR_W-1:0] P_LO   = ADDR_W'(PRIO_BASE);
    localparam logic [ADDR_W-1:0] P_SPAN = ADDR_W'(NUM_SRC * WORD_BYTES);
    localparam logic [ADDR_W-1:0] Q_LO   = ADDR_W'(PEND_BASE);
    localparam logic [ADDR_W-1:0] Q_SPAN = ADDR_W'(WORDS * WORD_BYTES);
    localparam logic [ADDR_W-1:0] E_LO   = ADDR_W'(ENA_BASE);
    localparam logic [ADDR_W-1:0] E_SPAN = ADDR_W'(NUM_CTX * ENA_STRIDE);
    localparam logic [ADDR_W-1:0] E_MASK = ADDR_W'(ENA_STRIDE - 1);
    localparam logic [ADDR_W-1:0] C_LO   = ADDR_W'(CTX_BASE);
    localparam logic [ADDR_W-1:0] C_SPAN = ADDR_W'(NUM_CTX * CTX_STRIDE);
    localparam logic [ADDR_W-1:0] C_MASK = ADDR_W'(CTX_STRIDE - 1);

    logic [ADDR_W-1:0] off_p, off_q, off_e, off_c, e_word, c_off;

    // Offsets from each base; unsigned wrap turns each range test into one compare
    always_comb begin
        off_p  = addr_i - P_LO;
        off_q  = addr_i - Q_LO;
        off_e  = addr_i - E_LO;
        off_c  = addr_i - C_LO;
        e_word = (off_e & E_MASK) >> 2;
        c_off  = off_c & C_MASK;
    end

    // Region selection and index extraction
    always_comb begin
        region_o = RG_NONE;
        src_o    = '0;
        ctx_o    = '0;
        word_o   = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (off_p < P_SPAN) begin
                region_o = RG_PRIO;
                src_o    = SRC_W'(off_p >> 2) + SRC_W'(1);
            end else if (off_q < Q_SPAN) begin
                region_o = RG_PEND;
                word_o   = WRD_W'(off_q >> 2);
            end else if (off_e < E_SPAN) begin
                ctx_o = CTX_W'(off_e >> ESH);
                if (e_word < ADDR_W'(WORDS)) begin
                    region_o = RG_ENA;
                    word_o   = WRD_W'(e_word);
                end
            end else if (off_c < C_SPAN) begin
                ctx_o = CTX_W'(off_c >> CSH);
                if (c_off == '0) begin
                    region_o = RG_THR;
                end else if (c_off == ADDR_W'(4)) begin
                    region_o = RG_CLAIM;
                end
            end
        end
        ok_o = (region_o != RG_NONE) && !((region_o == RG_PEND) && we_i);
    end

endmodule

// File: rtl/intc_prio_store.sv
// Module intc_prio_store
// Per-source priority registers. Source ID 0 has no register and reads 0.
// Assumes: wr_src_i and rd_src_i lie in 1..NUM_SRC when used.
module intc_prio_store #(
    parameter int unsigned NUM_SRC = 40,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned SRC_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [SRC_W-1:0]              wr_src_i,
    input  logic [PRIO_W-1:0]             wr_data_i,
    input  logic [SRC_W-1:0]              rd_src_i,
    output logic [PRIO_W-1:0]             rd_data_o,
    output logic [(NUM_SRC+1)*PRIO_W-1:0] prio_o
);

    logic [PRIO_W-1:0] level_q [NUM_SRC+1];

    // Priority storage with synchronous reset; slot 0 is never written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s <= NUM_SRC; s++) begin
                level_q[s] <= '0;
            end
        end else if (wr_en_i && (wr_src_i != '0)) begin
            level_q[wr_src_i] <= wr_data_i;
        end
    end

    // Read port for the register interface
    assign rd_data_o = level_q[rd_src_i];

    // Flatten storage for the arbiter
    for (genvar s = 0; s <= NUM_SRC; s++) begin : g_flat
        assign prio_o[s*PRIO_W +: PRIO_W] = level_q[s];
    end

endmodule

// File: rtl/intc_ctx_store.sv
// Module intc_ctx_store
// Per-context enable bitmaps and priority thresholds. Threshold writes
// above MAX_PRIO are dropped here.
// Assumes: ctx_i < NUM_CTX and word_i < WORDS whenever a write is enabled.
module intc_ctx_store #(
    parameter int unsigned NUM_CTX  = 2,
    parameter int unsigned WORDS    = 2,
    parameter int unsigned PRIO_W   = 3,
    parameter int unsigned MAX_PRIO = 7,
    parameter int unsigned CTX_W    = 1,
    parameter int unsigned WRD_W    = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en_wr_i,
    input  logic                         thr_wr_i,
    input  logic [CTX_W-1:0]             ctx_i,
    input  logic [WRD_W-1:0]             word_i,
    input  logic [31:0]                  wdata_i,
    output logic [31:0]                  en_rd_o,
    output logic [PRIO_W-1:0]            thr_rd_o,
    output logic [NUM_CTX*WORDS*32-1:0]  enable_o,
    output logic [NUM_CTX*PRIO_W-1:0]    thresh_o
);

    logic [31:0]       en_q  [NUM_CTX][WORDS];
    logic [PRIO_W-1:0] thr_q [NUM_CTX];
    logic              thr_accept;

    // Threshold filter: values above the top priority are not stored
    assign thr_accept = thr_wr_i && (wdata_i <= 32'(MAX_PRIO));

    // Enable words, written whole
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                for (int w = 0; w < WORDS; w++) begin
                    en_q[c][w] <= '0;
                end
            end
        end else if (en_wr_i) begin
            en_q[ctx_i][word_i] <= wdata_i;
        end
    end

    // Threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                thr_q[c] <= '0;
            end
        end else if (thr_accept) begin
            thr_q[ctx_i] <= wdata_i[PRIO_W-1:0];
        end
    end

    // Read ports for the register interface
    assign en_rd_o  = en_q[ctx_i][word_i];
    assign thr_rd_o = thr_q[ctx_i];

    // Flatten storage for the arbiter
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        assign thresh_o[c*PRIO_W +: PRIO_W] = thr_q[c];
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign enable_o[(c*WORDS+w)*32 +: 32] = en_q[c][w];
        end
    end

endmodule

// File: rtl/intc_reg_decoder.sv
// Module intc_reg_decoder
// Register front end of the interrupt controller: decodes single-cycle
// requests, owns priority/enable/threshold storage, returns read data one
// cycle later and issues claim/complete strobes to the arbiter.
// Assumes: one request per cycle at most; best_id_i stays within 0..NUM_SRC.
module intc_reg_decoder
    import intc_reg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned NUM_SRC    = 40,
    parameter int unsigned NUM_CTX    = 2,
    parameter int unsigned PRIO_W     = 3,
    parameter int unsigned MAX_PRIO   = 7,
    parameter int unsigned PRIO_BASE  = 'h0,
    parameter int unsigned PEND_BASE  = 'h1000,
    parameter int unsigned ENA_BASE   = 'h2000,
    parameter int unsigned ENA_STRIDE = 'h80,
    parameter int unsigned CTX_BASE   = 'h200000,
    parameter int unsigned CTX_STRIDE = 'h1000,
    localparam int unsigned WORDS = (NUM_SRC + 1 + 31) / 32,
    localparam int unsigned ID_W  = $clog2(NUM_SRC + 1),
    localparam int unsigned CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int unsigned WRD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_i,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [31:0]                   wdata_i,
    output logic                          rvalid_o,
    output logic [31:0]                   rdata_o,
    output logic                          err_o,
    input  logic [NUM_SRC:0]              pend_i,
    input  logic [NUM_CTX*ID_W-1:0]       best_id_i,
    output logic                          claim_stb_o,
    output logic [CTX_W-1:0]              claim_ctx_o,
    output logic                          cmpl_stb_o,
    output logic [CTX_W-1:0]              cmpl_ctx_o,
    output logic [ID_W-1:0]               cmpl_id_o,
    output logic [(NUM_SRC+1)*PRIO_W-1:0] prio_o,
    output logic [NUM_CTX*WORDS*32-1:0]   enable_o,
    output logic [NUM_CTX*PRIO_W-1:0]     thresh_o
);

    region_e           region;
    logic              acc_ok;
    logic [ID_W-1:0]   src;
    logic [CTX_W-1:0]  ctx;
    logic [WRD_W-1:0]  word;
    logic              rd_req, wr_req;
    logic [PRIO_W-1:0] prio_rd, thr_rd;
    logic [31:0]       en_rd, rd_val;
    logic [WORDS*32-1:0] pend_pad;
    logic [31:0]       pend_w [WORDS];
    logic [ID_W-1:0]   best_w [NUM_CTX];

    intc_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .WORDS(WORDS),
        .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .ENA_BASE(ENA_BASE),
        .ENA_STRIDE(ENA_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE),
        .SRC_W(ID_W), .CTX_W(CTX_W), .WRD_W(WRD_W)
    ) u_decode (
        .addr_i  (addr_i),
        .we_i    (we_i),
        .region_o(region),
        .ok_o    (acc_ok),
        .src_o   (src),
        .ctx_o   (ctx),
        .word_o  (word)
    );

    // Request qualifiers
    assign rd_req = req_i && !we_i;
    assign wr_req = req_i && we_i;

    intc_prio_store #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(ID_W)
    ) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_req && (region == RG_PRIO)),
        .wr_src_i (src),
        .wr_data_i(wdata_i[PRIO_W-1:0]),
        .rd_src_i (src),
        .rd_data_o(prio_rd),
        .prio_o   (prio_o)
    );

    intc_ctx_store #(
        .NUM_CTX(NUM_CTX), .WORDS(WORDS), .PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO),
        .CTX_W(CTX_W), .WRD_W(WRD_W)
    ) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr_i (wr_req && (region == RG_ENA)),
        .thr_wr_i(wr_req && (region == RG_THR)),
        .ctx_i   (ctx),
        .word_i  (word),
        .wdata_i (wdata_i),
        .en_rd_o (en_rd),
        .thr_rd_o(thr_rd),
        .enable_o(enable_o),
        .thresh_o(thresh_o)
    );

    // Pending bitmap padded to whole words, and per-context claim IDs
    assign pend_pad = (WORDS*32)'(pend_i);
    for (genvar w = 0; w < WORDS; w++) begin : g_pend
        assign pend_w[w] = pend_pad[w*32 +: 32];
    end
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_best
        assign best_w[c] = best_id_i[c*ID_W +: ID_W];
    end

    // Read data selection by region
    always_comb begin
        unique case (region)
            RG_PRIO:  rd_val = 32'(prio_rd);
            RG_PEND:  rd_val = pend_w[word];
            RG_ENA:   rd_val = en_rd;
            RG_THR:   rd_val = 32'(thr_rd);
            RG_CLAIM: rd_val = 32'(best_w[ctx]);
            default:  rd_val = '0;
        endcase
    end

    // Claim and complete strobes to the arbiter, in the request cycle
    assign claim_stb_o = rd_req && (region == RG_CLAIM);
    assign claim_ctx_o = ctx;
    assign cmpl_stb_o  = wr_req && (region == RG_CLAIM) && (wdata_i <= 32'(NUM_SRC));
    assign cmpl_ctx_o  = ctx;
    assign cmpl_id_o   = wdata_i[ID_W-1:0];

    // Registered response: valid, data and error one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
            err_o    <= 1'b0;
        end else begin
            rvalid_o <= rd_req;
            err_o    <= req_i && !acc_ok;
            rdata_o  <= (rd_req && acc_ok) ? rd_val : '0;
        end
    end

endmodule

// File: rtl/intc_reg_decoder_chk.sv
// Module intc_reg_decoder_chk
// Protocol and state checks for intc_reg_decoder, attached with bind.
// Assumes: inputs are known whenever reset is released.
module intc_reg_decoder_chk #(
    parameter int unsigned NUM_SRC = 40,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned NUM_CTX = 2,
    parameter int unsigned WORDS   = 2,
    parameter int unsigned ID_W    = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_i,
    input logic                          we_i,
    input logic [1:0]                    lo_addr,
    input logic                          rvalid_o,
    input logic [31:0]                   rdata_o,
    input logic                          err_o,
    input logic                          claim_stb_o,
    input logic                          cmpl_stb_o,
    input logic [ID_W-1:0]               cmpl_id_o,
    input logic [(NUM_SRC+1)*PRIO_W-1:0] prio_o,
    input logic [NUM_CTX*WORDS*32-1:0]   enable_o,
    input logic [NUM_CTX*PRIO_W-1:0]     thresh_o
);

    assert_misaligned_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (lo_addr != 2'b00)) |=> err_o);

    assert_state_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && we_i) |=> ($stable(prio_o) && $stable(enable_o) && $stable(thresh_o)));

    assert_claim_answered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_stb_o |=> (rvalid_o && !err_o));

    assert_cmpl_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_stb_o |-> (we_i && (32'(cmpl_id_o) <= NUM_SRC)));

    assert_err_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && err_o) |-> (rdata_o == '0));

    assert_rvalid_follows_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(req_i && !we_i));

    assert_read_gets_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i) |=> rvalid_o);

    assert_err_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_i));

    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(claim_stb_o && cmpl_stb_o));

endmodule

bind intc_reg_decoder intc_reg_decoder_chk #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .NUM_CTX(NUM_CTX), .WORDS(WORDS), .ID_W(ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .we_i       (we_i),
    .lo_addr    (addr_i[1:0]),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o),
    .err_o      (err_o),
    .claim_stb_o(claim_stb_o),
    .cmpl_stb_o (cmpl_stb_o),
    .cmpl_id_o  (cmpl_id_o),
    .prio_o     (prio_o),
    .enable_o   (enable_o),
    .thresh_o   (thresh_o)
);

// File: tb/intc_reg_decoder_bench.sv
// Bench for intc_reg_decoder: behavioural register model, per-access
// response checks and a state comparison on every clock.
module intc_reg_decoder_bench;

    localparam int NUM_SRC = 40;
    localparam int NCTX    = 2;
    localparam int NWORDS  = 2;
    localparam int PEND_B  = 'h1000;
    localparam int ENA_B   = 'h2000;
    localparam int ENA_S   = 'h80;
    localparam int CTX_B   = 'h200000;
    localparam int CTX_S   = 'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        rvalid_o, err_o, claim_stb_o, cmpl_stb_o;
    logic [31:0] rdata_o;
    logic        claim_ctx_o, cmpl_ctx_o;
    logic [5:0]  cmpl_id_o;
    logic [NUM_SRC:0] pend_i;
    logic [11:0] best_id_i;
    logic [(NUM_SRC+1)*3-1:0] prio_o;
    logic [NCTX*NWORDS*32-1:0] enable_o;
    logic [NCTX*3-1:0] thresh_o;

    int          m_prio [NUM_SRC+1];
    logic [31:0] m_en   [NCTX][NWORDS];
    int          m_thr  [NCTX];
    int          m_best [NCTX];
    logic [63:0] pend_vec = '0;
    int checks = 0;
    int errors = 0;
    bit live = 1'b0;

    assign pend_i    = pend_vec[NUM_SRC:0];
    assign best_id_i = {6'(m_best[1]), 6'(m_best[0])};

    always #5 clk = ~clk;

    intc_reg_decoder u_intc_reg_decoder (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .err_o(err_o),
        .pend_i(pend_i), .best_id_i(best_id_i), .claim_stb_o(claim_stb_o),
        .claim_ctx_o(claim_ctx_o), .cmpl_stb_o(cmpl_stb_o), .cmpl_ctx_o(cmpl_ctx_o),
        .cmpl_id_o(cmpl_id_o), .prio_o(prio_o), .enable_o(enable_o), .thresh_o(thresh_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Register model: expected response and strobes; applies writes when asked
    function automatic void model(input bit apply, input bit we, input logic [23:0] a,
                                  input logic [31:0] d, output bit e, output logic [31:0] rd,
                                  output bit cl, output int clc, output bit cp,
                                  output int cpc, output int cpi);
        int ia, c, w, o;
        ia = int'(a);
        e = 1'b1; rd = '0; cl = 1'b0; clc = 0; cp = 1'b0; cpc = 0; cpi = 0;
        if (ia % 4 != 0) return;
        if (ia < NUM_SRC*4) begin
            e = 1'b0;
            if (we) begin if (apply) m_prio[ia/4+1] = int'(d % 8); end
            else rd = 32'(m_prio[ia/4+1]);
        end else if (ia >= PEND_B && ia < PEND_B + NWORDS*4) begin
            if (!we) begin e = 1'b0; rd = pend_vec[(ia-PEND_B)*8 +: 32]; end
        end else if (ia >= ENA_B && ia < ENA_B + NCTX*ENA_S) begin
            c = (ia-ENA_B)/ENA_S; w = ((ia-ENA_B)%ENA_S)/4;
            if (w < NWORDS) begin
                e = 1'b0;
                if (we) begin if (apply) m_en[c][w] = d; end
                else rd = m_en[c][w];
            end
        end else if (ia >= CTX_B && ia < CTX_B + NCTX*CTX_S) begin
            c = (ia-CTX_B)/CTX_S; o = (ia-CTX_B)%CTX_S;
            if (o == 0) begin
                e = 1'b0;
                if (we) begin if (apply && d <= 7) m_thr[c] = int'(d); end
                else rd = 32'(m_thr[c]);
            end else if (o == 4) begin
                e = 1'b0;
                if (we) begin
                    if (d <= NUM_SRC) begin cp = 1'b1; cpc = c; cpi = int'(d); end
                end else begin
                    cl = 1'b1; clc = c; rd = 32'(m_best[c]);
                end
            end
        end
    endfunction

    // One access followed by one idle cycle
    task automatic acc(bit we, logic [23:0] a, logic [31:0] d, string tag);
        bit e, cl, cp, e2, cl2, cp2;
        logic [31:0] rd, rd2;
        int clc, cpc, cpi, x1, x2, x3;
        @(negedge clk);
        req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
        model(1'b0, we, a, d, e, rd, cl, clc, cp, cpc, cpi);
        #1;
        chk(tag, "claim strobe", 32'(claim_stb_o), 32'(cl));
        if (cl) chk(tag, "claim ctx", 32'(claim_ctx_o), 32'(clc));
        chk(tag, "complete strobe", 32'(cmpl_stb_o), 32'(cp));
        if (cp) begin
            chk(tag, "complete ctx", 32'(cmpl_ctx_o), 32'(cpc));
            chk(tag, "complete id", 32'(cmpl_id_o), 32'(cpi));
        end
        @(posedge clk);
        model(1'b1, we, a, d, e2, rd2, cl2, x1, cp2, x2, x3);
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        #1;
        chk(tag, "rvalid", 32'(rvalid_o), 32'(!we));
        chk(tag, "err", 32'(err_o), 32'(e));
        if (!we) chk(tag, "rdata", rdata_o, rd);
    endtask

    // State outputs against the model on every clock (R2, R4, R5)
    always @(negedge clk) begin : state_cmp
        bit bad;
        if (live) begin
            #2;
            bad = 1'b0;
            for (int s = 0; s <= NUM_SRC; s++)
                if (prio_o[s*3 +: 3] !== 3'(m_prio[s])) bad = 1'b1;
            for (int c = 0; c < NCTX; c++) begin
                if (thresh_o[c*3 +: 3] !== 3'(m_thr[c])) bad = 1'b1;
                for (int w = 0; w < NWORDS; w++)
                    if (enable_o[(c*NWORDS+w)*32 +: 32] !== m_en[c][w]) bad = 1'b1;
            end
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL R2/R4/R5 state outputs: actual prio=%h en=%h thr=%h differ from model",
                         prio_o, enable_o, thresh_o);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s <= NUM_SRC; s++) m_prio[s] = 0;
        for (int c = 0; c < NCTX; c++) begin
            m_thr[c] = 0;
            m_best[c] = 0;
            for (int w = 0; w < NWORDS; w++) m_en[c][w] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs quiet while in reset
        chk("R10", "rvalid in reset", 32'(rvalid_o), 32'd0);
        chk("R10", "err in reset", 32'(err_o), 32'd0);
        chk("R10", "claim strobe in reset", 32'(claim_stb_o), 32'd0);
        chk("R10", "complete strobe in reset", 32'(cmpl_stb_o), 32'd0);
        chk("R10", "enables in reset", 32'(|enable_o), 32'd0);
        rst_n = 1'b1;
        live = 1'b1;

        acc(1'b0, 24'h000000, 32'h0, "R10 prio reads zero");
        acc(1'b0, 24'h002000, 32'h0, "R10 enable reads zero");
        acc(1'b0, 24'h201000, 32'h0, "R10 threshold reads zero");

        acc(1'b1, 24'h000000, 32'hFFFF_FFF5, "R2 write src1 masked");
        acc(1'b1, 24'h00009C, 32'h0000_0003, "R2 write src40");
        acc(1'b1, 24'h000010, 32'h0000_000E, "R2 write src5 masked");
        acc(1'b0, 24'h000000, 32'h0, "R2 read src1");
        acc(1'b0, 24'h00009C, 32'h0, "R2 read src40");
        acc(1'b0, 24'h000010, 32'h0, "R2 read src5");

        pend_vec = 64'h0000_01A5_8000_0012;
        acc(1'b0, 24'h001000, 32'h0, "R3 pending word0");
        acc(1'b0, 24'h001004, 32'h0, "R3 pending word1");
        acc(1'b1, 24'h001000, 32'hFFFF_FFFF, "R3 pending write rejected");

        acc(1'b1, 24'h002000, 32'hA5A5_0001, "R4 enable c0 w0");
        acc(1'b1, 24'h002084, 32'h0000_00FF, "R4 enable c1 w1");
        acc(1'b0, 24'h002000, 32'h0, "R4 read c0 w0");
        acc(1'b0, 24'h002084, 32'h0, "R4 read c1 w1");
        acc(1'b1, 24'h002008, 32'h1234_5678, "R4 word beyond bitmap write");
        acc(1'b0, 24'h002088, 32'h0, "R4 word beyond bitmap read");

        acc(1'b1, 24'h200000, 32'h0000_0007, "R5 threshold c0 max");
        acc(1'b1, 24'h200000, 32'h0000_0008, "R5 threshold above max ignored");
        acc(1'b1, 24'h200000, 32'h8000_0002, "R5 threshold huge ignored");
        acc(1'b0, 24'h200000, 32'h0, "R5 threshold c0 read");
        acc(1'b1, 24'h201000, 32'h0000_0003, "R5 threshold c1");
        acc(1'b0, 24'h201000, 32'h0, "R5 threshold c1 read");

        m_best[0] = 5; m_best[1] = 12;
        acc(1'b0, 24'h200004, 32'h0, "R6 claim c0");
        acc(1'b0, 24'h201004, 32'h0, "R6 claim c1");
        m_best[1] = 0;
        acc(1'b0, 24'h201004, 32'h0, "R6 claim c1 none");

        acc(1'b1, 24'h201004, 32'h0000_0009, "R7 complete c1 id9");
        acc(1'b1, 24'h200004, 32'h0000_0028, "R7 complete c0 id40");
        acc(1'b1, 24'h200004, 32'h0000_0029, "R7 complete id41 dropped");

        acc(1'b0, 24'h200008, 32'h0, "R8 bad ctx offset read");
        acc(1'b1, 24'h201008, 32'h7, "R8 bad ctx offset write");
        acc(1'b0, 24'h003000, 32'h0, "R8 unmapped read");
        acc(1'b1, 24'h0000A0, 32'h5, "R8 past priority region write");

        acc(1'b0, 24'h000002, 32'h0, "R1 misaligned read");
        acc(1'b1, 24'h002001, 32'hFFFF_FFFF, "R1 misaligned enable write");
        acc(1'b1, 24'h000005, 32'h1, "R1 misaligned prio write");
        acc(1'b0, 24'h002000, 32'h0, "R1 enable unchanged");

        // R9: a write returns no rvalid, a read returns exactly one
        @(negedge clk);
        chk("R9", "idle rvalid", 32'(rvalid_o), 32'd0);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule